// File: doc/BRIEF.md
# Triple-Rail Reset Supervisor with Watchdog

This block is the synchronous decision logic of a three-supply reset supervisor. External comparators give one under-voltage flag per rail. An active-low push-button input and a heartbeat input from the supervised processor come in beside them. The block drives an active-low system reset and an active-low watchdog alarm. All timeouts are counted in clock cycles.

The system reset is held while any rail is low or the push-button is pressed. It is then stretched for a fixed number of cycles after the last of these conditions clears. The watchdog alarm goes low when the heartbeat holds one level for too long, and it stays low until the heartbeat toggles again. The alarm also follows rail under-voltage directly, and it releases as soon as the rails recover. A watchdog timeout never touches the system reset.

Reset state machine (`sup_reset_fsm`):
- States are HOLD, STRETCH and RUN.
- Transitions are *release* (HOLD to STRETCH once no condition is active), *expire* (STRETCH to RUN once the count completes), *restart* (STRETCH to HOLD when a condition returns) and *fault* (RUN to HOLD).

Watchdog state machine (`sup_wdog_fsm`):
- States are IDLE, COUNT and EXPIRED.
- Transitions are *arm* (IDLE to COUNT when the hold drops), *disarm* (COUNT to IDLE under hold), *overflow* (COUNT to EXPIRED), *kick* (an edge in COUNT zeroes the counter) and *recover* (EXPIRED to COUNT or IDLE on an edge).

Top module: `rail_supervisor`

## Requirements
- R1: `rst_out_n` goes low two clock edges after any bit of `uv_flag` is set, and three edges after `man_rst_n` goes low. Both inputs go through input registers, and `man_rst_n` uses a two-flop synchronizer.
- R2: When the last active `uv_flag` bit clears, `rst_out_n` stays low and then rises exactly RST_CYC+2 edges later. The count starts from the last rail to recover.
- R3: When `man_rst_n` returns high, `rst_out_n` rises exactly RST_CYC+3 edges later.
- R4: If a reset condition returns while the stretch is running, the stretch restarts from zero once that condition clears again.
- R5: While `rst_n` is low, `rst_out_n` is 0 and `wd_out_n` is 1. After `rst_n` is released, `rst_out_n` rises after exactly RST_CYC edges.
- R6: Every rising or falling edge of `wd_in` clears the watchdog counter. A heartbeat that toggles at intervals shorter than WD_CYC keeps `wd_out_n` high.
- R7: If `wd_in` holds still, `wd_out_n` falls WD_CYC+3 edges after its last transition. After a reset release with no transition, it falls WD_CYC+1 edges after `rst_out_n` rises.
- R8: After a timeout, `wd_out_n` stays low for as long as `wd_in` is steady. It rises three edges after the next transition of `wd_in`.
- R9: `wd_out_n` is low one edge after a rail flag is set. It rises one edge after all rail flags clear, with no stretch.
- R10: The watchdog counter is held clear while `rst_out_n` is low or the synchronized manual reset is low. No timeout occurs in that time, however long `wd_in` holds still.
- R11: A watchdog timeout has no effect on `rst_out_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| uv_flag | input | NUM_RAILS | Per-rail under-voltage flag, 1 = below threshold |
| man_rst_n | input | 1 | Push-button reset, active low, asynchronous |
| wd_in | input | 1 | Heartbeat input, asynchronous |
| rst_out_n | output | 1 | System reset, active low |
| wd_out_n | output | 1 | Watchdog alarm, active low |

## Verification
The assertions assume that `uv_flag` is already synchronous to `clk`. They also assume that the heartbeat and push-button inputs change no more than once per clock, so the synchronizers never hide a transition. The stimulus changes every input one nanosecond after a rising edge and holds each level for at least one whole cycle. Heartbeat toggles are kept well below WD_CYC apart whenever a timeout is not the intended outcome.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        RS_HOLD    = 2'd0,
        RS_STRETCH = 2'd1,
        RS_RUN     = 2'd2
    } rst_state_e;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_COUNT   = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/sup_reset_fsm.sv
module sup_reset_fsm
    import sup_pkg::*;
#(
    parameter int RST_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic rst_out_n
);

    localparam int CW = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

    rst_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_STRETCH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_HOLD: begin
                cnt_d = '0;
                if (!cond) state_d = RS_STRETCH;
            end
            RS_STRETCH: begin
                if (cond) begin
                    state_d = RS_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = RS_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RS_RUN: begin
                if (cond) state_d = RS_HOLD;
            end
            default: state_d = RS_HOLD;
        endcase
    end

    always_comb begin
        rst_out_n = (state_q == RS_RUN);
    end

    p_cond_asserts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cond |=> !rst_out_n);

    p_release_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(!cond));

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_STRETCH && cond) |=> state_q == RS_HOLD);

endmodule

// File: rtl/sup_wdog_fsm.sv
module sup_wdog_fsm
    import sup_pkg::*;
#(
    parameter int WD_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_sync,
    input  logic hold,
    output logic expired
);

    localparam int CW = $clog2(WD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WD_CYC - 1);

    wd_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          prev_q;
    logic          edge_seen;

    assign edge_seen = wd_sync ^ prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= wd_sync;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WD_IDLE: begin
                cnt_d = '0;
                if (!hold) state_d = WD_COUNT;
            end
            WD_COUNT: begin
                if (hold) begin
                    state_d = WD_IDLE;
                    cnt_d   = '0;
                end else if (edge_seen) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    state_d = WD_EXPIRED;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            WD_EXPIRED: begin
                cnt_d = '0;
                if (edge_seen) state_d = hold ? WD_IDLE : WD_COUNT;
            end
            default: state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        expired = (state_q == WD_EXPIRED);
    end

    p_kick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !hold) |=> state_q != WD_EXPIRED);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_COUNT) |-> cnt_q <= LAST);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_EXPIRED && !edge_seen) |=> state_q == WD_EXPIRED);

    p_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && state_q != WD_EXPIRED) |=> state_q != WD_EXPIRED);

endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
    parameter int NUM_RAILS   = 3,
    parameter int SYNC_STAGES = 2,
    parameter int RST_CYC     = 2_000_000,
    parameter int WD_CYC      = 16_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] uv_flag,
    input  logic                 man_rst_n,
    input  logic                 wd_in,
    output logic                 rst_out_n,
    output logic                 wd_out_n
);

    logic uv_q;
    logic mr_s;
    logic wd_s;
    logic rst_cond;
    logic wd_hold;
    logic wd_expired;

    always_ff @(posedge clk) begin
        if (!rst_n) uv_q <= 1'b0;
        else        uv_q <= |uv_flag;
    end

    sup_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_mr_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (man_rst_n),
        .sync_out (mr_s)
    );

    sup_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_wd_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wd_in),
        .sync_out (wd_s)
    );

    assign rst_cond = uv_q | ~mr_s;

    sup_reset_fsm #(.RST_CYC(RST_CYC)) u_reset (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond      (rst_cond),
        .rst_out_n (rst_out_n)
    );

    assign wd_hold = ~rst_out_n | ~mr_s;

    sup_wdog_fsm #(.WD_CYC(WD_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .wd_sync (wd_s),
        .hold    (wd_hold),
        .expired (wd_expired)
    );

    assign wd_out_n = ~(wd_expired | uv_q);

    p_uv_alarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_q |-> !wd_out_n);

    p_uv_alarm_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uv_q) && !wd_expired |-> wd_out_n);

endmodule

// File: tb/rail_supervisor_test.sv
`timescale 1ns/1ps
module rail_supervisor_test;

    localparam int RC = 8;
    localparam int WC = 12;

    typedef struct {
        int    cyc;
        bit    is_rst;
        bit    val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] uv_flag = 3'b000;
    logic       man_rst_n = 1'b1;
    logic       wd_in = 1'b0;
    logic       rst_out_n;
    logic       wd_out_n;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rail_supervisor #(.NUM_RAILS(3), .SYNC_STAGES(2), .RST_CYC(RC), .WD_CYC(WC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .uv_flag   (uv_flag),
        .man_rst_n (man_rst_n),
        .wd_in     (wd_in),
        .rst_out_n (rst_out_n),
        .wd_out_n  (wd_out_n)
    );

    task automatic expect_at(int c, bit is_rst, bit val, string tag);
        exp_t e;
        e.cyc = c; e.is_rst = is_rst; e.val = val; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic kick();
        wd_in = ~wd_in;
    endtask

    // monitor: compares outputs against queued expectations at falling edges
    always @(negedge clk) begin
        exp_t keep[$];
        keep = {};
        foreach (sb_q[i]) begin
            if (sb_q[i].cyc == cyc) begin
                logic act;
                act = sb_q[i].is_rst ? rst_out_n : wd_out_n;
                checks++;
                if (act !== sb_q[i].val) begin
                    failures++;
                    $display("FAIL %s cyc=%0d %s actual=%b expected=%b", sb_q[i].tag, cyc,
                             sb_q[i].is_rst ? "rst_out_n" : "wd_out_n", act, sb_q[i].val);
                end
            end else if (sb_q[i].cyc < cyc) begin
                checks++;
                failures++;
                $display("FAIL %s missed cyc=%0d actual=none expected=%b", sb_q[i].tag,
                         sb_q[i].cyc, sb_q[i].val);
            end else begin
                keep.push_back(sb_q[i]);
            end
        end
        sb_q = keep;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        // R5: power-on state and release
        step(3);
        expect_at(cyc, 1, 1'b0, "R5");
        expect_at(cyc, 0, 1'b1, "R5");
        n = cyc;
        rst_n = 1'b1;
        expect_at(n + RC - 1, 1, 1'b0, "R5");
        expect_at(n + RC, 1, 1'b1, "R5");
        // R7: timeout after release with no heartbeat
        expect_at(n + RC + WC, 0, 1'b1, "R7");
        expect_at(n + RC + WC + 1, 0, 1'b0, "R7");
        // R11: timeout leaves reset alone
        expect_at(n + RC + WC + 6, 1, 1'b1, "R11");
        step(RC + WC + 8);

        // R8: recover on edge, then sticky timeout
        n = cyc;
        kick();
        expect_at(n + 2, 0, 1'b0, "R8");
        expect_at(n + 3, 0, 1'b1, "R8");
        expect_at(n + WC + 2, 0, 1'b1, "R7");
        expect_at(n + WC + 3, 0, 1'b0, "R7");
        expect_at(n + WC + 20, 0, 1'b0, "R8");
        expect_at(n + WC + 20, 1, 1'b1, "R11");
        step(WC + 22);

        // R6: regular heartbeat keeps alarm high, both edge directions
        n = cyc;
        kick();
        expect_at(n + 3, 0, 1'b1, "R8");
        for (int k = 0; k < 10; k++) begin
            step(6);
            kick();
            expect_at(cyc + 5, 0, 1'b1, "R6");
        end
        n = cyc;
        expect_at(n + WC + 2, 0, 1'b1, "R7");
        expect_at(n + WC + 3, 0, 1'b0, "R7");
        step(WC + 5);

        // R1 R2 R9 R10: each rail in turn
        for (int r = 0; r < 3; r++) begin
            int m, d;
            kick();
            expect_at(cyc + 3, 0, 1'b1, "R8");
            step(5);
            m = cyc;
            uv_flag[r] = 1'b1;
            expect_at(m + 1, 1, 1'b1, "R1");
            expect_at(m + 2, 1, 1'b0, "R1");
            expect_at(m + 1, 0, 1'b0, "R9");
            expect_at(m + 19, 0, 1'b0, "R9");
            step(20);
            d = cyc;
            uv_flag[r] = 1'b0;
            expect_at(d + 1, 0, 1'b1, "R9");
            expect_at(d + RC + 1, 0, 1'b1, "R10");
            expect_at(d + RC + 1, 1, 1'b0, "R2");
            expect_at(d + RC + 2, 1, 1'b1, "R2");
            step(RC + 4);
        end

        // R4: condition returns during stretch
        begin
            int d, d2;
            kick();
            step(5);
            uv_flag[2] = 1'b1;
            step(10);
            d = cyc;
            uv_flag[2] = 1'b0;
            step(4);
            uv_flag[2] = 1'b1;
            step(1);
            d2 = cyc;
            uv_flag[2] = 1'b0;
            expect_at(d + RC + 2, 1, 1'b0, "R4");
            expect_at(d2 + RC + 1, 1, 1'b0, "R4");
            expect_at(d2 + RC + 2, 1, 1'b1, "R4");
            step(RC + 4);
        end

        // R2: release counted from the last rail to recover
        begin
            int d0, d1;
            kick();
            step(5);
            uv_flag = 3'b011;
            step(10);
            d0 = cyc;
            uv_flag[0] = 1'b0;
            step(5);
            d1 = cyc;
            uv_flag[1] = 1'b0;
            expect_at(d0 + RC + 2, 1, 1'b0, "R2");
            expect_at(d1 + RC + 1, 1, 1'b0, "R2");
            expect_at(d1 + RC + 2, 1, 1'b1, "R2");
            step(RC + 4);
        end

        // R1 R3 R10: manual reset, heartbeat steady for a long hold
        begin
            int p;
            kick();
            step(4);
            n = cyc;
            man_rst_n = 1'b0;
            expect_at(n + 2, 1, 1'b1, "R1");
            expect_at(n + 3, 1, 1'b0, "R1");
            expect_at(n + 3, 0, 1'b1, "R10");
            expect_at(n + 40, 0, 1'b1, "R10");
            step(40);
            p = cyc;
            man_rst_n = 1'b1;
            expect_at(p + RC + 2, 1, 1'b0, "R3");
            expect_at(p + RC + 3, 1, 1'b1, "R3");
            expect_at(p + RC + 3, 0, 1'b1, "R10");
            step(RC + 5);
        end

        step(3);
        wait (sb_q.size() == 0);
        step(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule